// File: doc/BRIEF.md
# Reset Supervisor With Loop-Strobe Watchdog

This block drives the system reset for a controller and the peripherals beside it. It watches three things. The first is a power-good indication. The second is a digital undervoltage flag from an external comparator on the 5 V rail. The third is a strobe that the controller's firmware raises once per pass of its main loop, namely the enable it uses to read its configuration switches. From these it produces an active-high reset and a relay-inoperative alarm.

Once power is good, the reset is stretched to a fixed length, 50 ms by default. The length is derived from the clock frequency parameter. While the undervoltage flag is raised, reset is held without limit. When the flag drops, a complete fresh pulse follows.

The watchdog runs only while reset is released. It starts again from zero on every rising edge of the loop strobe. If no rising edge arrives within the timeout, it fires a full reset pulse. It also latches a fault that keeps the alarm raised until the firmware proves it is alive again with a new strobe edge. The undervoltage flag and the strobe each pass through a two-flop synchroniser before use.

Top module: `rsup_top`

## Requirements
- R1: While `pwr_ok` is low, `sys_rst` is high and `alarm` is low; a latched watchdog fault is cleared.
- R2: After `pwr_ok` is seen high, `sys_rst` stays high for exactly RST_CYC clock cycles, where RST_CYC = (CLK_HZ/1000)·RST_MS, and then falls.
- R3: Within 3 cycles of `uv_flag` rising, both `sys_rst` and `alarm` are high, and both stay high for as long as `uv_flag` stays high, however long that is.
- R4: When `uv_flag` falls, `sys_rst` stays high for exactly RST_CYC+3 cycles counted from the cycle the flag is driven low; the 3 extra cycles are the two synchroniser stages and the state update.
- R5: With `sys_rst` low and no rising edge on `loop_strobe`, `sys_rst` is low for exactly WDT_CYC cycles, where WDT_CYC = (CLK_HZ/1000)·WDT_MS. It then rises for a full RST_CYC-cycle pulse.
- R6: Rising edges of `loop_strobe` spaced closer than WDT_CYC cycles keep `sys_rst` low indefinitely.
- R7: A `loop_strobe` that is held high counts as a single feed. If the strobe goes high on the first cycle that `sys_rst` is low and stays high, `sys_rst` is low for exactly WDT_CYC+3 cycles.
- R8: The watchdog does not count while `sys_rst` is high, so an undervoltage hold longer than WDT_CYC leaves no fault behind: `alarm` is low once the flag clears.
- R9: After a watchdog timeout, `alarm` stays high through the reset pulse and afterwards, until a rising edge of `loop_strobe`. It is low 3 cycles after that edge is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock, CLK_HZ |
| pwr_ok | input | 1 | Power-good; low acts as synchronous clear of the block |
| uv_flag | input | 1 | High while the 5 V rail is below its threshold (asynchronous) |
| loop_strobe | input | 1 | Main-loop switch-read enable from the controller (asynchronous) |
| sys_rst | output | 1 | Active-high reset to controller and peripherals |
| alarm | output | 1 | Relay-inoperative alarm: undervoltage hold or watchdog fault |

## Verification
The assertions assume that `pwr_ok` is synchronous to `clk` and starts low, so every property has its clear active from time zero. They also assume RST_CYC and WDT_CYC are at least 2, which lets a one-cycle reset or run window be treated as a violation. The bench drives all inputs on the falling clock edge and starts with `pwr_ok` low. It runs with a 1 kHz nominal frequency, giving 50- and 100-cycle windows. It keeps strobe high times and undervoltage holds far apart from the windows being measured, so each expected cycle count has a single answer.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

    typedef enum logic [1:0] {
        SUP_PULSE = 2'd0,
        SUP_HOLD  = 2'd1,
        SUP_RUN   = 2'd2
    } sup_state_e;

    localparam int unsigned SYNC_STAGES = 2;

    function automatic longint unsigned ms_to_cycles(longint unsigned hz, longint unsigned ms);
        return (hz / 64'd1000) * ms;
    endfunction

    function automatic int unsigned cnt_width(longint unsigned n);
        return (n < 64'd2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             srst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int unsigned CHAIN_W = WIDTH * STAGES;

    logic [CHAIN_W-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (srst) chain <= '0;
                else      chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (srst) chain <= '0;
                else      chain <= {chain[CHAIN_W-WIDTH-1:0], d};
            end
        end
    endgenerate

    assign q = chain[CHAIN_W-1 -: WIDTH];

endmodule

// File: rtl/rsup_stretch.sv
module rsup_stretch
    import rsup_pkg::*;
#(
    parameter int unsigned RST_CYC = 10_000_000
) (
    input  logic clk,
    input  logic srst,
    input  logic uv_i,
    input  logic trip_i,
    output logic rst_o,
    output logic hold_o,
    output logic run_o
);
    localparam int unsigned CW = cnt_width(64'(RST_CYC));
    localparam logic [CW-1:0] LAST = CW'(RST_CYC - 1);

    sup_state_e    state;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (srst) begin
            state <= SUP_PULSE;
            cnt   <= '0;
        end else begin
            unique case (state)
                SUP_PULSE: begin
                    if (uv_i) begin
                        state <= SUP_HOLD;
                        cnt   <= '0;
                    end else if (cnt == LAST) begin
                        state <= SUP_RUN;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SUP_HOLD: begin
                    cnt <= '0;
                    if (!uv_i) state <= SUP_PULSE;
                end
                SUP_RUN: begin
                    cnt <= '0;
                    if (uv_i)        state <= SUP_HOLD;
                    else if (trip_i) state <= SUP_PULSE;
                end
                default: begin
                    state <= SUP_PULSE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    assign rst_o  = (state != SUP_RUN);
    assign hold_o = (state == SUP_HOLD);
    assign run_o  = (state == SUP_RUN);

    AST_PULSE_NOT_SHORT: assert property (@(posedge clk) disable iff (srst)
        $rose(rst_o) |=> rst_o); // R2
    AST_HOLD_WHILE_LOW: assert property (@(posedge clk) disable iff (srst)
        (hold_o && uv_i) |=> hold_o); // R3

endmodule

// File: rtl/rsup_wdog.sv
module rsup_wdog
    import rsup_pkg::*;
#(
    parameter int unsigned WDT_CYC = 20_000_000
) (
    input  logic clk,
    input  logic srst,
    input  logic run_i,
    input  logic stb_i,
    output logic trip_o,
    output logic fault_o
);
    localparam int unsigned CW = cnt_width(64'(WDT_CYC));
    localparam logic [CW-1:0] LAST = CW'(WDT_CYC - 1);

    logic          stb_d;
    logic          rise;
    logic [CW-1:0] cnt;
    logic          fault_q;

    assign rise   = stb_i & ~stb_d;
    assign trip_o = run_i & ~rise & (cnt == LAST);

    always_ff @(posedge clk) begin
        if (srst) begin
            stb_d   <= 1'b0;
            cnt     <= '0;
            fault_q <= 1'b0;
        end else begin
            stb_d <= stb_i;
            if (!run_i || rise || trip_o) cnt <= '0;
            else                          cnt <= cnt + 1'b1;
            if (trip_o)    fault_q <= 1'b1;
            else if (rise) fault_q <= 1'b0;
        end
    end

    assign fault_o = fault_q;

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (srst)
        (fault_q && !rise) |=> fault_q); // R9
    AST_FEED_NO_TRIP: assert property (@(posedge clk) disable iff (srst)
        rise |=> !trip_o); // R6

endmodule

// File: rtl/rsup_top.sv
module rsup_top
    import rsup_pkg::*;
#(
    parameter int unsigned CLK_HZ = 200_000_000,
    parameter int unsigned RST_MS = 50,
    parameter int unsigned WDT_MS = 100
) (
    input  logic clk,
    input  logic pwr_ok,
    input  logic uv_flag,
    input  logic loop_strobe,
    output logic sys_rst,
    output logic alarm
);
    localparam int unsigned RST_CYC = int'(ms_to_cycles(64'(CLK_HZ), 64'(RST_MS)));
    localparam int unsigned WDT_CYC = int'(ms_to_cycles(64'(CLK_HZ), 64'(WDT_MS)));

    logic       srst;
    logic [1:0] raw_in;
    logic [1:0] syn_in;
    logic       uv_s;
    logic       stb_s;
    logic       trip;
    logic       hold;
    logic       run;
    logic       fault;

    assign srst   = ~pwr_ok;
    assign raw_in = {uv_flag, loop_strobe};

    rsup_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .srst (srst),
        .d    (raw_in),
        .q    (syn_in)
    );

    assign uv_s  = syn_in[1];
    assign stb_s = syn_in[0];

    rsup_stretch #(.RST_CYC(RST_CYC)) u_stretch (
        .clk    (clk),
        .srst   (srst),
        .uv_i   (uv_s),
        .trip_i (trip),
        .rst_o  (sys_rst),
        .hold_o (hold),
        .run_o  (run)
    );

    rsup_wdog #(.WDT_CYC(WDT_CYC)) u_wdog (
        .clk     (clk),
        .srst    (srst),
        .run_i   (run),
        .stb_i   (stb_s),
        .trip_o  (trip),
        .fault_o (fault)
    );

    assign alarm = hold | fault;

    AST_UV_FORCES_RST: assert property (@(posedge clk) disable iff (srst)
        uv_s |=> (sys_rst && alarm)); // R3
    AST_TRIP_FORCES_RST: assert property (@(posedge clk) disable iff (srst)
        trip |=> (sys_rst && alarm)); // R5
    AST_RUN_NOT_SHORT: assert property (@(posedge clk) disable iff (srst)
        $fell(sys_rst) |=> !sys_rst); // R5
    AST_CLEAR_ON_PWR: assert property (@(posedge clk)
        !pwr_ok |=> (sys_rst && !alarm)); // R1

endmodule

// File: tb/tb_rsup_top.sv
`timescale 1ns/1ps
module tb_rsup_top;
    localparam int unsigned RST_N = 50;
    localparam int unsigned WDT_N = 100;

    logic clk = 1'b0;
    logic pwr_ok = 1'b0;
    logic uv_flag = 1'b0;
    logic loop_strobe = 1'b0;
    logic sys_rst;
    logic alarm;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rsup_top #(.CLK_HZ(1000), .RST_MS(RST_N), .WDT_MS(WDT_N)) dut (
        .clk         (clk),
        .pwr_ok      (pwr_ok),
        .uv_flag     (uv_flag),
        .loop_strobe (loop_strobe),
        .sys_rst     (sys_rst),
        .alarm       (alarm)
    );

    // phase word: {uv, feed, exp_rst, exp_alarm, cycles[15:0]}
    localparam int NPH = 7;
    localparam logic [19:0] PH [NPH] = '{
        {1'b0, 1'b1, 1'b0, 1'b0, 16'd300}, // R6 regular feed
        {1'b1, 1'b0, 1'b1, 1'b1, 16'd10},  // R3 undervoltage seen
        {1'b1, 1'b0, 1'b1, 1'b1, 16'd300}, // R3 long hold
        {1'b0, 1'b0, 1'b1, 1'b0, 16'd20},  // R4 R8 recovery pulse running
        {1'b0, 1'b1, 1'b0, 1'b0, 16'd60},  // R8 no stale fault
        {1'b0, 1'b0, 1'b0, 1'b1, 16'd200}, // R9 timeout fault latched
        {1'b0, 1'b1, 1'b0, 1'b0, 16'd30}   // R9 fault cleared by feed
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic measure(input logic level, output int n);
        n = 0;
        while (sys_rst === level && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (4) @(negedge clk);
        chk("R1 rst in clear", int'(sys_rst), 1);
        chk("R1 alarm in clear", int'(alarm), 0);

        pwr_ok = 1'b1;
        measure(1'b1, n);
        chk("R2 power-up pulse length", n, RST_N);

        measure(1'b0, n);
        chk("R5 timeout run length", n, WDT_N);
        chk("R9 alarm at trip", int'(alarm), 1);
        measure(1'b1, n);
        chk("R5 watchdog pulse length", n, RST_N);
        chk("R9 alarm after pulse", int'(alarm), 1);

        // R7 stuck-high strobe, R9 clear after edge
        loop_strobe = 1'b1;
        n = 0;
        while (sys_rst === 1'b0 && n < 5000) begin
            n++;
            if (n == 4) chk("R9 alarm cleared by edge", int'(alarm), 0);
            @(negedge clk);
        end
        chk("R7 stuck strobe run length", n, WDT_N + 3);
        chk("R7 alarm on stuck strobe", int'(alarm), 1);
        loop_strobe = 1'b0;
        measure(1'b1, n);
        chk("R5 second pulse length", n, RST_N);

        for (int p = 0; p < NPH; p++) begin
            for (int i = 0; i < int'(PH[p][15:0]); i++) begin
                uv_flag = PH[p][19];
                loop_strobe = PH[p][18] && ((i % 20) < 4);
                @(negedge clk);
            end
            chk($sformatf("phase %0d rst (R3 R4 R6 R8 R9)", p), int'(sys_rst), int'(PH[p][17]));
            chk($sformatf("phase %0d alarm (R3 R8 R9)", p), int'(alarm), int'(PH[p][16]));
        end
        loop_strobe = 1'b0;

        // R3 per-cycle hold check, then R4 recovery length
        uv_flag = 1'b1;
        repeat (3) @(negedge clk);
        n = 0;
        for (int i = 0; i < 250; i++) begin
            if (sys_rst !== 1'b1 || alarm !== 1'b1) n++;
            @(negedge clk);
        end
        chk("R3 hold without gaps", n, 0);
        uv_flag = 1'b0;
        measure(1'b1, n);
        chk("R4 recovery pulse length", n, RST_N + 3);
        chk("R8 no fault after hold", int'(alarm), 0);

        pwr_ok = 1'b0;
        @(negedge clk);
        chk("R1 rst on power loss", int'(sys_rst), 1);
        chk("R1 alarm on power loss", int'(alarm), 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule